// File: doc/BRIEF.md
# Multiplexed DRAM Nibble Access Sequencer

This block drives a byte-wide memory built from four single-bit-wide dynamic RAM devices that together hold 64K half-bytes. Since each device access returns only four bits, a byte is fetched as two column reads inside one row cycle. The block runs from a 16 MHz clock and cuts time into access windows of eight clock phases (500 ns each). In each window it drives the multiplexed address lines and the active-low row and column strobes, then assembles the two half-bytes into a byte.

Windows alternate between a video requester and a processor requester, so each side owns one window per microsecond. The window that follows reset belongs to video. A requester asks for a byte by holding its request flag and byte address across the boundary into its own window. The byte then appears with a one-cycle valid pulse and a tag naming the owner. A request raised during the other side's window has no effect.

Top module: `nibble_dram_seq`

## Requirements
- R1: While reset is held, rowStrobeN and colStrobeN are 1, byteValid is 0, memAddr is 0 and byteData is 0.
- R2: Windows are 8 cycles long and alternate video, processor, video, and so on, starting with video after reset. A window is served only if its owner's request is 1 on the clock edge that starts the window's phase 0. The other requester's flag and address have no effect on that window.
- R3: In a served window, memAddr in phase 0 equals byte address bits 14 to 7 (the row). rowStrobeN is 0 in phases 1 through 6 and 1 in phases 0 and 7.
- R4: In a served window, memAddr in phases 1 to 3 equals {address bits 6..0, 1'b0}, and in phases 4 to 7 equals {address bits 6..0, 1'b1}. memAddr is stable while colStrobeN stays low.
- R5: In a served window, colStrobeN is 0 in phases 2, 3, 5 and 6 and 1 in phases 0, 1, 4 and 7. colStrobeN is never 0 while rowStrobeN is 1.
- R6: byteData[7:4] is the memData value present at the end of phase 3, and byteData[3:0] is the memData value present at the end of phase 6.
- R7: byteValid is 1 for exactly one cycle, in phase 7 of a served window. In that cycle byteOwner is 1 for a processor window and 0 for a video window. byteData and byteOwner hold their values until the next served window.
- R8: In a window that is not served, rowStrobeN and colStrobeN stay 1, memAddr stays 0 and byteValid stays 0 for all eight phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz phase clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vidReq | input | 1 | Video request for its next window |
| vidAddr | input | 15 | Video byte address |
| cpuReq | input | 1 | Processor request for its next window |
| cpuAddr | input | 15 | Processor byte address |
| memData | input | 4 | Half-byte returned by the four devices |
| memAddr | output | 8 | Multiplexed row/column address lines |
| rowStrobeN | output | 1 | Row address strobe, active low |
| colStrobeN | output | 1 | Column address strobe, active low |
| byteData | output | 8 | Assembled byte |
| byteValid | output | 1 | One-cycle pulse marking a new byte |
| byteOwner | output | 1 | 1 when the byte belongs to the processor |

## Verification
Random addresses over the whole byte space, together with a memory model whose half-byte depends on both latched row and column, show whether the row and the two column addresses are split and ordered correctly, and whether the halves land in the right nibble. Windows where both sides request with different addresses show whether ownership alternates correctly. Windows where only the non-owner requests, or where nobody does, show that the strobes stay quiet and that the last byte is held. Addresses at zero and at all ones test the edges of the row and column fields.

// File: rtl/nds_pkg.sv
package nds_pkg;

  // Phase numbers inside one 500 ns access window.
  localparam int PHASES     = 8;
  localparam int PH_W       = $clog2(PHASES);
  localparam int PH_ROW     = 0;
  localparam int PH_COL_HI  = 1;
  localparam int PH_CAS_HI  = 2;
  localparam int PH_GET_HI  = 3;
  localparam int PH_COL_LO  = 4;
  localparam int PH_CAS_LO  = 5;
  localparam int PH_GET_LO  = 6;
  localparam int PH_END     = 7;

  typedef enum logic [1:0] {
    ADR_NONE,
    ADR_ROW,
    ADR_COL_HI,
    ADR_COL_LO
  } adrSel_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic    load;     // capture an address for the coming window
    logic    loadCpu;  // the coming window belongs to the processor
    logic    rasAct;
    logic    casAct;
    adrSel_e adrSel;
    logic    latchHi;
    logic    latchLo;
    logic    winCpu;   // current window owner
  } strb_t;

endpackage

// File: rtl/nds_ctrl.sv
module nds_ctrl
  import nds_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  vidReq,
  input  logic  cpuReq,
  output strb_t strb
);

  logic [PH_W-1:0] phase;
  logic            winCpu;
  logic            busy;
  logic            lastPh;
  logic            nextReq;

  assign lastPh  = (phase == PH_W'(PH_END));
  // The window after the current one is owned by the other side.
  assign nextReq = winCpu ? vidReq : cpuReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_W'(PH_END);
      winCpu <= 1'b1;
      busy   <= 1'b0;
    end else begin
      if (lastPh) begin
        phase  <= '0;
        winCpu <= ~winCpu;
        busy   <= nextReq;
      end else begin
        phase  <= phase + PH_W'(1);
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.winCpu  = winCpu;
    strb.load    = lastPh && nextReq;
    strb.loadCpu = ~winCpu;
    strb.adrSel  = ADR_NONE;
    if (busy) begin
      strb.rasAct  = (phase >= PH_W'(PH_COL_HI)) && (phase <= PH_W'(PH_GET_LO));
      strb.casAct  = (phase == PH_W'(PH_CAS_HI)) || (phase == PH_W'(PH_GET_HI)) ||
                     (phase == PH_W'(PH_CAS_LO)) || (phase == PH_W'(PH_GET_LO));
      strb.latchHi = (phase == PH_W'(PH_GET_HI));
      strb.latchLo = (phase == PH_W'(PH_GET_LO));
      if (phase == PH_W'(PH_ROW))
        strb.adrSel = ADR_ROW;
      else if (phase < PH_W'(PH_COL_LO))
        strb.adrSel = ADR_COL_HI;
      else
        strb.adrSel = ADR_COL_LO;
    end
  end

endmodule

// File: rtl/nds_datapath.sv
module nds_datapath
  import nds_pkg::*;
#(
  parameter int MA_W  = 8,
  parameter int NIB_W = 4,
  localparam int ADDR_W = 2 * MA_W - 1,
  localparam int COL_W  = MA_W - 1,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [ADDR_W-1:0] vidAddr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [NIB_W-1:0]  memData,
  output logic [MA_W-1:0]   memAddr,
  output logic              rowStrobeN,
  output logic              colStrobeN,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              byteOwner
);

  logic [ADDR_W-1:0] addrQ;
  logic [NIB_W-1:0]  hiQ;
  logic [MA_W-1:0]   rowPart;
  logic [COL_W-1:0]  colPart;

  assign rowPart = addrQ[COL_W +: MA_W];
  assign colPart = addrQ[COL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      hiQ       <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
      byteOwner <= 1'b0;
    end else begin
      if (strb.load)
        addrQ <= strb.loadCpu ? cpuAddr : vidAddr;
      if (strb.latchHi)
        hiQ <= memData;
      if (strb.latchLo) begin
        byteData  <= {hiQ, memData};
        byteOwner <= strb.winCpu;
      end
      byteValid <= strb.latchLo;
    end
  end

  always_comb begin
    unique case (strb.adrSel)
      ADR_ROW:    memAddr = rowPart;
      ADR_COL_HI: memAddr = {colPart, 1'b0};
      ADR_COL_LO: memAddr = {colPart, 1'b1};
      default:    memAddr = '0;
    endcase
  end

  assign rowStrobeN = ~strb.rasAct;
  assign colStrobeN = ~strb.casAct;

endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq
  import nds_pkg::*;
#(
  parameter int MA_W  = 8,
  parameter int NIB_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                vidReq,
  input  logic [2*MA_W-2:0]   vidAddr,
  input  logic                cpuReq,
  input  logic [2*MA_W-2:0]   cpuAddr,
  input  logic [NIB_W-1:0]    memData,
  output logic [MA_W-1:0]     memAddr,
  output logic                rowStrobeN,
  output logic                colStrobeN,
  output logic [2*NIB_W-1:0]  byteData,
  output logic                byteValid,
  output logic                byteOwner
);

  strb_t strb;

  nds_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .vidReq (vidReq),
    .cpuReq (cpuReq),
    .strb   (strb)
  );

  nds_datapath #(
    .MA_W  (MA_W),
    .NIB_W (NIB_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .vidAddr    (vidAddr),
    .cpuAddr    (cpuAddr),
    .memData    (memData),
    .memAddr    (memAddr),
    .rowStrobeN (rowStrobeN),
    .colStrobeN (colStrobeN),
    .byteData   (byteData),
    .byteValid  (byteValid),
    .byteOwner  (byteOwner)
  );

endmodule

// File: rtl/nds_checker.sv
module nds_checker #(
  parameter int MA_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            rowStrobeN,
  input logic            colStrobeN,
  input logic            byteValid,
  input logic [MA_W-1:0] memAddr
);

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !colStrobeN |-> !rowStrobeN); // R5

  AST_RAS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rowStrobeN) |=> !rowStrobeN); // R3

  AST_ADDR_HELD_CAS: assert property (@(posedge clk) disable iff (!rstN)
    (!colStrobeN && $past(!colStrobeN)) |-> $stable(memAddr)); // R4

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R7

  AST_VALID_AFTER_ROW: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (rowStrobeN && $past(!rowStrobeN))); // R7

endmodule

bind nibble_dram_seq nds_checker #(.MA_W(MA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rowStrobeN (rowStrobeN),
  .colStrobeN (colStrobeN),
  .byteValid  (byteValid),
  .memAddr    (memAddr)
);

// File: tb/tb_nibble_dram_seq.sv
`timescale 1ns/1ps
module tb_nibble_dram_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vidReq = 1'b0;
  logic [14:0] vidAddr = '0;
  logic        cpuReq = 1'b0;
  logic [14:0] cpuAddr = '0;
  logic [3:0]  memData;
  logic [7:0]  memAddr;
  logic        rowStrobeN, colStrobeN;
  logic [7:0]  byteData;
  logic        byteValid, byteOwner;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  nibble_dram_seq dut (
    .clk(clk), .rstN(rstN),
    .vidReq(vidReq), .vidAddr(vidAddr),
    .cpuReq(cpuReq), .cpuAddr(cpuAddr),
    .memData(memData), .memAddr(memAddr),
    .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .byteData(byteData), .byteValid(byteValid), .byteOwner(byteOwner)
  );

  // Memory model: strobes latch the address seen in the preceding half cycle.
  logic [7:0] addrPrev = '0;
  logic [7:0] rowL = '0;
  logic [7:0] colL = '0;
  always @(negedge clk) addrPrev = memAddr;
  always @(negedge rowStrobeN) rowL = addrPrev;
  always @(negedge colStrobeN) colL = addrPrev;

  function automatic logic [3:0] nibOf(input logic [7:0] r, input logic [7:0] c);
    logic [7:0] t;
    t = (r * 8'd5) ^ (c * 8'd29) ^ {c[3:0], c[7:4]} ^ 8'h5A;
    return t[3:0] ^ t[7:4];
  endfunction

  assign memData = nibOf(rowL, colL);

  function automatic logic [7:0] expByte(input logic [14:0] a);
    return {nibOf(a[14:7], {a[6:0], 1'b0}), nibOf(a[14:7], {a[6:0], 1'b1})};
  endfunction

  function automatic logic [7:0] expAddr(input int k, input logic [14:0] a);
    if (k == 0) return a[14:7];
    if (k < 4)  return {a[6:0], 1'b0};
    return {a[6:0], 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic       nextCpu = 1'b0;
  logic [7:0] lastByte = '0;
  logic       lastOwner = 1'b0;

  // Called at a negedge in phase 7 (or in reset); runs one full window.
  task automatic runWindow(input logic vR, input logic [14:0] vA,
                           input logic cR, input logic [14:0] cA);
    logic        isCpu, served;
    logic [14:0] a;
    logic [7:0]  eb;
    isCpu  = nextCpu;
    served = isCpu ? cR : vR;
    a      = isCpu ? cA : vA;
    eb     = expByte(a);
    vidReq = vR; vidAddr = vA; cpuReq = cR; cpuAddr = cA;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (served) begin
        chk(rowStrobeN == ((k >= 1 && k <= 6) ? 1'b0 : 1'b1), "R3 rowStrobeN", {15'd0, rowStrobeN}, 16'(k));
        chk(colStrobeN == ((k == 2 || k == 3 || k == 5 || k == 6) ? 1'b0 : 1'b1), "R5 colStrobeN", {15'd0, colStrobeN}, 16'(k));
        chk(memAddr == expAddr(k, a), (k == 0) ? "R3 row addr" : "R4 col addr", {8'd0, memAddr}, {8'd0, expAddr(k, a)});
      end else begin
        chk(rowStrobeN && colStrobeN && memAddr == 8'd0, "R8 idle lines", {6'd0, rowStrobeN, colStrobeN, memAddr}, 16'h0300);
      end
      if (k == 7) begin
        chk(byteValid == served, "R7 valid pulse", {15'd0, byteValid}, {15'd0, served});
        if (served) begin
          chk(byteData == eb, "R6 byte assembly", {8'd0, byteData}, {8'd0, eb});
          chk(byteOwner == isCpu, "R2 R7 owner", {15'd0, byteOwner}, {15'd0, isCpu});
          lastByte = eb; lastOwner = isCpu;
        end else begin
          chk(byteData == lastByte && byteOwner == lastOwner, "R7 R8 hold", {7'd0, byteOwner, byteData}, {7'd0, lastOwner, lastByte});
        end
      end else begin
        chk(byteValid == 1'b0, "R7 no early valid", {15'd0, byteValid}, 16'd0);
      end
    end
    nextCpu = ~nextCpu;
  endtask

  initial begin
    #(8 * 190000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rowStrobeN && colStrobeN && !byteValid && memAddr == 8'd0 && byteData == 8'd0,
        "R1 reset state", {6'd0, rowStrobeN, colStrobeN, memAddr}, 16'h0300);
    rstN = 1'b1;

    // Directed corner cases (first window is video).
    runWindow(1'b1, 15'h0000, 1'b0, 15'h0000);   // R3 R4 zero address
    runWindow(1'b1, 15'h1111, 1'b1, 15'h7FFF);   // R2 cpu all ones, video ignored
    runWindow(1'b1, 15'h4A5C, 1'b1, 15'h2222);   // R2 both request, video owns
    runWindow(1'b1, 15'h3333, 1'b0, 15'h0101);   // R2 R8 only non-owner requests
    runWindow(1'b0, 15'h0000, 1'b0, 15'h0000);   // R8 nobody requests
    runWindow(1'b0, 15'h0000, 1'b1, 15'h007F);   // R4 column field all ones
    runWindow(1'b1, 15'h7F80, 1'b0, 15'h0000);   // R3 row field all ones
    runWindow(1'b0, 15'h0000, 1'b1, 15'h7FFF);   // R6 owner processor

    // Random windows.
    for (int i = 0; i < 400; i++) begin
      runWindow(($urandom % 4) != 0, 15'($urandom), ($urandom % 4) != 0, 15'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule